// File: doc/BRIEF.md
# External Multiplexed Bus Strobe Sequencer

This block drives the external memory pins of a small microcontroller whose code and data share one multiplexed bus. The low byte of each address and the data byte share one bidirectional port. A second port carries the high address byte. Each machine cycle lasts twelve oscillator periods, and the block runs one clock per oscillator period. A free-running phase counter (0 to 11) sets the shape of every strobe.

At phase 11 the block samples its requests and picks the kind of the next machine cycle. A data request wins over code execution. If neither is present, the cycle is idle. A code-fetch cycle reads two bytes, at the program counter and at the next address. Each byte gets its own address-latch pulse and its own program-store strobe, so the returned bytes must be consumed as two per machine cycle. A data cycle sends one address, then one read or write strobe. In a data cycle the second address-latch pulse and both program-store strobes are left out. For a data access the high port carries the upper pointer byte when the address is 16 bits wide. When the address is 8 bits wide, it carries the contents of the port-2 output register instead. An optional 4 KiB limit mode clears the top four high-address bits on every external access.

Top module: `ext_bus_seq`

## Requirements
- R1: In fetch and idle cycles, `ale` is high in phases 0-1 and 6-7 and low otherwise. The address is valid one period before `ale` falls and held one period after it falls.
- R2: While an address is being sent, `p0_oe` is 1 and `p0_out` carries the low address byte. This covers phases 0-2 of each half of a fetch cycle and phases 0-2 of a data cycle. `p0_oe` is 0 throughout idle cycles.
- R3: In a fetch cycle, `psen_n` is low in phases 3-5 and 9-11, and the low port is tri-stated during those phases. The byte on `p0_in` is captured on the clock edge that ends phase 5 (address = program counter) and on the edge that ends phase 11 (address = program counter + 1, wrapping to 0 past 16'hFFFF). `code_valid` is high for the one period that follows each capture.
- R4: In a data cycle, `ale` is high only in phases 0-1, and `psen_n` stays high for the whole cycle.
- R5: A read drives `rd_n` low in phases 5-10 (6 periods, starting 3 periods after `ale` falls), with the low port tri-stated from phase 3. The byte is captured on the edge that ends phase 10, and `rdata_valid` is high during phase 11.
- R6: A write drives `wr_n` low in phases 5-10, ending one period before the next `ale` rise. `p0_out` holds the write data with `p0_oe` = 1 in phases 3-11.
- R7: `p2_out` carries the high address byte of the current fetch byte in a fetch cycle. It carries `daddr[15:8]` in a data cycle with `dwide` = 1, and `p2_reg` in a data cycle with `dwide` = 0. In idle cycles it carries the live `p2_reg`.
- R8: When `lim4k` was 1 at the phase-11 sample, `p2_out[7:4]` is 0 throughout that fetch or data cycle. Idle cycles are not masked.
- R9: `dreq` is sampled at phase 11 and has priority over `fetch_en`. When both are high, the next cycle is a data cycle with no program-store strobe.
- R10: While `rst` is high, the phase is 0 and the cycle is idle. `psen_n`, `rd_n` and `wr_n` are 1, `p0_oe`, `code_valid` and `rdata_valid` are 0, and `ale` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_en | input | 1 | Code execution from external memory requested |
| pc | input | 16 | Program counter for the next fetch cycle |
| dreq | input | 1 | Data access requested |
| dwe | input | 1 | 1 = write, 0 = read |
| dwide | input | 1 | 1 = 16-bit pointer address, 0 = 8-bit indirect address |
| daddr | input | 16 | Data address (upper byte used only when dwide = 1) |
| wdata | input | 8 | Write data |
| p2_reg | input | 8 | Port-2 output register contents |
| lim4k | input | 1 | Clear the top four high-address bits on external accesses |
| p0_in | input | 8 | Low port pin input |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Low port output value |
| p0_oe | output | 1 | Low port output enable |
| p2_out | output | 8 | High port output value |
| code_byte | output | 8 | Last captured code byte |
| code_valid | output | 1 | code_byte updated, one period |
| rdata | output | 8 | Last captured read byte |
| rdata_valid | output | 1 | rdata updated, one period |

## Verification
The bench runs a sequence of cycles:
- idle cycles,
- long fetch runs,
- a fetch at 16'hFFFF, which shows whether the second byte wraps its address,
- reads and writes with both address widths, which shows whether the high port picks the pointer byte or the port register,
- the same accesses with the 4 KiB limit on, which shows whether masking applies to external cycles and leaves idle cycles alone,
- cycles with data and fetch requested together, which shows whether priority suppresses the program-store strobes.

The bench models external memory as a latch on the falling edge of the address strobe followed by a fixed function of the latched address. Every captured byte therefore shows whether the capture edge and the address order are right.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq (
  input  logic        clk,
  input  logic        rst,
  input  logic        fetch_en,
  input  logic [15:0] pc,
  input  logic        dreq,
  input  logic        dwe,
  input  logic        dwide,
  input  logic [15:0] daddr,
  input  logic [7:0]  wdata,
  input  logic [7:0]  p2_reg,
  input  logic        lim4k,
  input  logic [7:0]  p0_in,
  output logic        ale,
  output logic        psen_n,
  output logic        rd_n,
  output logic        wr_n,
  output logic [7:0]  p0_out,
  output logic        p0_oe,
  output logic [7:0]  p2_out,
  output logic [7:0]  code_byte,
  output logic        code_valid,
  output logic [7:0]  rdata,
  output logic        rdata_valid
);
  localparam logic [3:0] LAST_PH = 4'd11;
  localparam logic [3:0] HALF    = 4'd6;

  typedef enum logic [1:0] {CY_IDLE, CY_FETCH, CY_DATA} cyc_t;

  logic [3:0]  ph;
  cyc_t        cyc;
  logic [15:0] base;
  logic        we_q, lim_q;
  logic [7:0]  wd_q;

  wire        hi_half = (ph >= HALF);
  wire [3:0]  sub     = hi_half ? ph - HALF : ph;
  wire        is_f    = (cyc == CY_FETCH);
  wire        is_d    = (cyc == CY_DATA);
  wire [15:0] xa      = is_f ? base + {15'd0, hi_half} : base;
  wire [7:0]  xhi     = lim_q ? {4'd0, xa[11:8]} : xa[15:8];
  wire        strobe  = is_d && ph >= 4'd5 && ph <= 4'd10;
  wire        wphase  = is_d && we_q && ph >= 4'd3;

  assign ale    = (!is_d || !hi_half) && sub < 4'd2;
  assign psen_n = !(is_f && sub >= 4'd3);
  assign rd_n   = !(strobe && !we_q);
  assign wr_n   = !(strobe && we_q);
  assign p0_oe  = ((is_f || (is_d && !hi_half)) && sub <= 4'd2) || wphase;
  assign p0_out = !p0_oe ? 8'h00 : (wphase ? wd_q : xa[7:0]);
  assign p2_out = (cyc == CY_IDLE) ? p2_reg : xhi;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph          <= 4'd0;
      cyc         <= CY_IDLE;
      base        <= 16'h0000;
      we_q        <= 1'b0;
      lim_q       <= 1'b0;
      wd_q        <= 8'h00;
      code_byte   <= 8'h00;
      code_valid  <= 1'b0;
      rdata       <= 8'h00;
      rdata_valid <= 1'b0;
    end else begin
      code_valid  <= is_f && sub == 4'd5;
      rdata_valid <= is_d && !we_q && ph == 4'd10;
      if (is_f && sub == 4'd5) code_byte <= p0_in;
      if (is_d && !we_q && ph == 4'd10) rdata <= p0_in;
      if (ph == LAST_PH) begin
        ph    <= 4'd0;
        cyc   <= dreq ? CY_DATA : (fetch_en ? CY_FETCH : CY_IDLE);
        base  <= dreq ? {(dwide ? daddr[15:8] : p2_reg), daddr[7:0]} : pc;
        we_q  <= dwe;
        wd_q  <= wdata;
        lim_q <= lim4k;
      end else begin
        ph <= ph + 4'd1;
      end
    end
  end

  AST_ALE_TWO_WIDE: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> (ale ##1 !ale)); // R1
  AST_PSEN_THREE_WIDE: assert property (@(posedge clk) disable iff (rst)
    $fell(psen_n) |=> (!psen_n ##1 !psen_n ##1 psen_n)); // R3
  AST_PSEN_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> !p0_oe); // R3
  AST_NO_PSEN_IN_DATA: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> (psen_n && !ale)); // R4
  AST_RD_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !p0_oe); // R5
  AST_STROBE_AFTER_ALE: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_n) || $fell(wr_n)) |-> ($past(ale, 4) && !$past(ale, 3))); // R5
  AST_WR_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> p0_oe); // R6
  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n)); // R5
endmodule

// File: tb/sim_ext_bus_seq.sv
module sim_ext_bus_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, fetch_en, dreq, dwe, dwide, lim4k;
  logic [15:0] pc, daddr;
  logic [7:0]  wdata, p2_reg, p0_in;
  logic        ale, psen_n, rd_n, wr_n, p0_oe, code_valid, rdata_valid;
  logic [7:0]  p0_out, p2_out, code_byte, rdata;

  ext_bus_seq u0 (.clk(clk), .rst(rst), .fetch_en(fetch_en), .pc(pc), .dreq(dreq),
    .dwe(dwe), .dwide(dwide), .daddr(daddr), .wdata(wdata), .p2_reg(p2_reg),
    .lim4k(lim4k), .p0_in(p0_in), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out),
    .code_byte(code_byte), .code_valid(code_valid), .rdata(rdata),
    .rdata_valid(rdata_valid));

  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  logic [15:0] lat = 16'h0000;
  always @(negedge ale) lat = {p2_out, p0_out};
  assign p0_in = mem(lat);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural model: kind 0 idle, 1 fetch, 2 data
  int m_ph = 0, m_kind = 0;
  logic [15:0] m_a = 0;
  logic m_we = 0, m_lim = 0, m_both = 0, m_cv = 0, m_rv = 0;
  logic [7:0] m_wd = 0, m_code = 0, m_rd = 0;

  function automatic logic [15:0] m_ext(input int phase);
    logic [15:0] a;
    a = (m_kind == 1) ? m_a + ((phase >= 6) ? 16'd1 : 16'd0) : m_a;
    return m_lim ? (a & 16'h0FFF) : a;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_kind = 0; m_cv = 0; m_rv = 0;
    end else begin
      m_cv = 0; m_rv = 0;
      if (m_kind == 1 && (m_ph == 5 || m_ph == 11)) begin
        m_cv = 1; m_code = mem(m_ext(m_ph));
      end
      if (m_kind == 2 && !m_we && m_ph == 10) begin
        m_rv = 1; m_rd = mem(m_ext(m_ph));
      end
      if (m_ph == 11) begin
        m_kind = dreq ? 2 : (fetch_en ? 1 : 0);
        m_both = dreq && fetch_en;
        m_a    = dreq ? (dwide ? daddr : {p2_reg, daddr[7:0]}) : pc;
        m_we   = dwe; m_wd = wdata; m_lim = lim4k;
      end
      m_ph = (m_ph + 1) % 12;
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      check(ale && psen_n && rd_n && wr_n && !p0_oe && !code_valid && !rdata_valid,
            "R10", "reset outputs", {ale, psen_n, rd_n, wr_n, p0_oe, code_valid, rdata_valid},
            7'b1111000);
    end else if (!done) begin
      logic e_ale, e_psen, e_rd, e_wr, e_oe;
      logic [7:0] e_p0, e_p2;
      int s;
      s = m_ph % 6;
      e_ale  = (m_kind == 2) ? (m_ph < 2) : (s < 2);
      e_psen = !(m_kind == 1 && s >= 3);
      e_rd   = !(m_kind == 2 && !m_we && m_ph >= 5 && m_ph <= 10);
      e_wr   = !(m_kind == 2 && m_we && m_ph >= 5 && m_ph <= 10);
      e_oe   = (m_kind == 1 && s <= 2) || (m_kind == 2 && (m_ph <= 2 || (m_we && m_ph >= 3)));
      e_p0   = (m_kind == 2 && m_ph >= 3) ? m_wd : m_ext(m_ph) >> 0;
      e_p2   = (m_kind == 0) ? p2_reg : m_ext(m_ph) >> 8;
      check(ale === e_ale, (m_kind == 2) ? "R4" : "R1", "ale", ale, e_ale);
      check(psen_n === e_psen, m_both ? "R9" : ((m_kind == 2) ? "R4" : "R3"),
            "psen_n", psen_n, e_psen);
      check(rd_n === e_rd, "R5", "rd_n", rd_n, e_rd);
      check(wr_n === e_wr, "R6", "wr_n", wr_n, e_wr);
      check(p0_oe === e_oe, (m_we && m_ph >= 3) ? "R6" : "R2", "p0_oe", p0_oe, e_oe);
      if (e_oe)
        check(p0_out === e_p0, (m_kind == 2 && m_ph >= 3) ? "R6" : "R2", "p0_out", p0_out, e_p0);
      check(p2_out === e_p2, (m_lim && m_kind != 0) ? "R8" : "R7", "p2_out", p2_out, e_p2);
      check(code_valid === m_cv, "R3", "code_valid", code_valid, m_cv);
      if (m_cv) check(code_byte === m_code, "R3", "code_byte", code_byte, m_code);
      check(rdata_valid === m_rv, "R5", "rdata_valid", rdata_valid, m_rv);
      if (m_rv) check(rdata === m_rd, "R5", "rdata", rdata, m_rd);
    end
  end

  task automatic setup(input bit f, input logic [15:0] p, input bit d, input bit w,
                       input bit wide, input logic [15:0] da, input logic [7:0] wd,
                       input logic [7:0] p2, input bit lim, input int ncyc);
    fetch_en = f; pc = p; dreq = d; dwe = w; dwide = wide; daddr = da;
    wdata = wd; p2_reg = p2; lim4k = lim;
    repeat (ncyc * 12) @(negedge clk);
  endtask

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 20000 && !done) begin
      done = 1; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", wd_cnt, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1;
    setup(0, 16'h0, 0, 0, 0, 16'h0, 8'h00, 8'h3C, 0, 0);
    repeat (3) @(negedge clk);
    rst = 0;
    setup(0, 16'h0000, 0, 0, 0, 16'h0000, 8'h00, 8'h3C, 0, 2);                 // idle R1
    setup(1, 16'h1234, 0, 0, 0, 16'h0000, 8'h00, 8'h3C, 0, 3);                 // fetch R3
    setup(1, 16'hFFFF, 0, 0, 0, 16'h0000, 8'h00, 8'h3C, 0, 1);                 // wrap R3
    setup(0, 16'h0000, 1, 0, 1, 16'hABCD, 8'h00, 8'h3C, 0, 2);                 // read wide R5 R7
    setup(0, 16'h0000, 1, 0, 0, 16'h7756, 8'h00, 8'h9C, 0, 2);                 // read narrow R7
    setup(0, 16'h0000, 1, 1, 1, 16'h3210, 8'hE7, 8'h9C, 0, 2);                 // write wide R6
    setup(0, 16'h0000, 1, 1, 0, 16'h5511, 8'h4B, 8'hC3, 0, 2);                 // write narrow R6
    setup(1, 16'hF7F0, 0, 0, 0, 16'h0000, 8'h00, 8'hC3, 1, 2);                 // fetch masked R8
    setup(0, 16'h0000, 1, 0, 1, 16'hFEDC, 8'h00, 8'hC3, 1, 2);                 // read masked R8
    setup(0, 16'h0000, 1, 1, 0, 16'h0099, 8'h21, 8'hFF, 1, 2);                 // narrow masked R8
    setup(1, 16'h8001, 1, 0, 1, 16'h4242, 8'h00, 8'h10, 0, 2);                 // both R9
    setup(1, 16'h8001, 1, 1, 1, 16'h2424, 8'h6D, 8'h10, 0, 1);                 // both write R9
    setup(0, 16'h0000, 0, 0, 0, 16'h0000, 8'h00, 8'hF0, 1, 2);                 // idle unmasked R8
    setup(1, 16'h00FE, 0, 0, 0, 16'h0000, 8'h00, 8'hF0, 0, 2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule